// File: doc/BRIEF.md
# Fully Associative Multi-Size TLB Lookup

This block is one side of a translation buffer for a 64-bit virtual address machine. It holds a parameterized number of entries (64 by default), each pairing a tag (virtual page number and a 13-bit context) with a translation word. The translation word carries a physical frame number, a 2-bit size code and the attribute flags: valid, global, privileged, writable, side-effect, no-fault-only and used. A lookup compares every entry in parallel. Each entry ignores the virtual page bits below its own page size, so 8 KB, 64 KB, 512 KB and 4 MB pages can sit side by side in the same array.

A request carries the virtual address, an access kind (load, store, non-faulting load, instruction fetch), a context selector, a user flag and a trap-level flag. The block picks the context, finds the lowest-indexed matching entry and forms a 41-bit page frame address. It then grants permissions or raises a miss, fault or protection exception, and updates the fault status, fault address and tag access registers. Entries are loaded through a separate write port by index. Refill and table walking are handled elsewhere.

Top module: `mmu_tlb_lookup`

## Requirements
- R1: After reset every entry is invalid, rsp_valid is 0, and fault_status, fault_addr and tag_access are all zero. A lookup issued after reset and before any write misses.
- R2: When wr_en is 1 at a clock edge, entry wr_idx takes wr_tag = {VA[63:13] at bits 63:13, context at bits 12:0}. It also takes wr_data, laid out as bits 27:0 frame PA[40:13], 29:28 size code, 30 valid, 31 global, 32 privileged, 33 writable, 34 side-effect, 35 no-fault-only, 36 used. A lookup requested in a later cycle sees the new contents.
- R3: A request sampled with req_valid at an edge produces its result on the outputs right after that edge, with rsp_valid 1 for exactly that cycle. rsp_valid is 0 in a cycle that follows an edge without a request.
- R4: Size code s (0..3) gives a page of 8 KB shifted left by 3*s. An entry compares only VA bits 63:(13+3*s) against its tag.
- R5: An entry hits when it is valid, its VA bits match, and it is either global or its context equals the selected context. req_ctx_sel chooses the data context: 0 primary, 1 secondary, 2 or 3 context 0 (nucleus).
- R6: On a successful hit, rsp_pa bits 40:(13+3*s) come from the entry frame and bits (12+3*s):13 come from the VA. Bits 12:0 are 0. rsp_pa is 0 whenever rsp_exc is not 0.
- R7: When several entries hit, the lowest index wins. rsp_index reports it, and rsp_used reports its used bit as it was before the lookup.
- R8: A data access raises a fault (rsp_exc = 2) in three cases: a user access to a privileged page, a non-faulting load to a side-effect page, or a load or store to a no-fault-only page.
- R9: A store to a non-writable page with no fault condition raises protection (rsp_exc = 3). Permissions are 0 on any exception.
- R10: A fault or protection exception writes fault_address = VA and writes fault_status. The status word holds bit 0 valid, bit 2 store, bit 3 non-faulting load, bits 5:4 context type (0 primary, 1 secondary, 2 nucleus), bit 6 privilege fault, bit 7 side-effect fault and bit 8 no-fault-only fault. Bit 1 (overflow) is set when bit 0 was already set.
- R11: A miss (rsp_exc = 1) leaves fault_status and fault_addr unchanged. A miss, fault or protection exception writes tag_access = {VA[63:13], selected context}.
- R12: A successful data hit grants rsp_perm = {read, write, execute} = 1, writable, 0. A successful fetch hit grants 3'b001. Either kind sets the entry's used bit.
- R13: A fetch (req_kind 3) uses the primary context when req_trap_nz is 0 and context 0 otherwise. It faults only for a user fetch of a privileged page, with context type 2 when req_trap_nz is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry index to load |
| wr_tag | input | 64 | Tag word {VA[63:13], context} |
| wr_data | input | 37 | Translation word |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 non-faulting load, 3 fetch |
| req_ctx_sel | input | 2 | Data context selector |
| req_user | input | 1 | User-mode access |
| req_trap_nz | input | 1 | Trap level above zero |
| prim_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| rsp_valid | output | 1 | Result valid |
| rsp_exc | output | 2 | 0 none, 1 miss, 2 fault, 3 protection |
| rsp_pa | output | 41 | Page frame address |
| rsp_perm | output | 3 | {read, write, execute} |
| rsp_index | output | 6 | Index of the selected entry (0 on a miss) |
| rsp_used | output | 1 | Used bit of the selected entry before the lookup |
| fault_status | output | 9 | Fault status register |
| fault_addr | output | 64 | Fault address register |
| tag_access | output | 64 | Tag access register |

## Verification
Every lookup result, together with the three fault registers, is due in the cycle that follows the edge sampling the request. An entry write takes effect for requests sampled at later edges. The bench drives a request on a falling edge, lets one rising edge pass, and samples all outputs on the next falling edge. It compares them against a model that it updates in the same step, including used bits and the status overflow. It never samples before that edge, and it issues writes only in cycles without a request, so no result depends on the ordering of a write and a lookup at the same edge.

// File: rtl/mmu_tlb_pkg.sv
package mmu_tlb_pkg;
    localparam int VA_W     = 64;
    localparam int PA_W     = 41;
    localparam int CTX_W    = 13;
    localparam int PG_SHIFT = 13;
    localparam int SIZE_W   = 2;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = PA_W - PG_SHIFT;
    localparam int DATA_W   = PPN_W + SIZE_W + 7;
    localparam int FSR_W    = 9;

    // fault status bit positions
    localparam int FS_VALID   = 0;
    localparam int FS_OVF     = 1;
    localparam int FS_WRITE   = 2;
    localparam int FS_NF      = 3;
    localparam int FS_CT_LO   = 4;
    localparam int FS_FT_PRIV = 6;
    localparam int FS_FT_SE   = 7;
    localparam int FS_FT_NFO  = 8;

    localparam logic [1:0] CT_PRIMARY   = 2'd0;
    localparam logic [1:0] CT_SECONDARY = 2'd1;
    localparam logic [1:0] CT_NUCLEUS   = 2'd2;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_NFLOAD = 2'd2,
        ACC_FETCH  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_MISS  = 2'd1,
        EXC_FAULT = 2'd2,
        EXC_PROT  = 2'd3
    } exc_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [CTX_W-1:0] ctx;
    } tlb_tag_t;

    typedef struct packed {
        logic              used;
        logic              nfo;
        logic              side;
        logic              wr;
        logic              priv;
        logic              glob;
        logic              valid;
        logic [SIZE_W-1:0] size;
        logic [PPN_W-1:0]  ppn;
    } tlb_data_t;
endpackage

// File: rtl/mmu_tlb_array.sv
module mmu_tlb_array
    import mmu_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_tag_t         wr_tag,
    input  tlb_data_t        wr_data,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output tlb_tag_t         tags_q  [ENTRIES],
    output tlb_data_t        datas_q [ENTRIES]
);
    tlb_tag_t  tags_d  [ENTRIES];
    tlb_data_t datas_d [ENTRIES];

    always_comb begin
        tags_d  = tags_q;
        datas_d = datas_q;
        if (touch_en) begin
            datas_d[touch_idx].used = 1'b1;
        end
        // a load by index replaces the whole entry, including a same-edge used update
        if (wr_en) begin
            tags_d[wr_idx]  = wr_tag;
            datas_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags_q[i]  <= '0;
                datas_q[i] <= '0;
            end
        end else begin
            tags_q  <= tags_d;
            datas_q <= datas_d;
        end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tags_q[$past(wr_idx)] == $past(wr_tag)) &&
                  (datas_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/mmu_tlb_cam.sv
module mmu_tlb_cam
    import mmu_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  tlb_tag_t         tags  [ENTRIES],
    input  tlb_data_t        datas [ENTRIES],
    input  logic [VPN_W-1:0] vpn,
    input  logic [CTX_W-1:0] ctx,
    output logic             hit,
    output logic [IDX_W-1:0] sel_idx,
    output tlb_data_t        sel,
    output logic [PPN_W-1:0] pa_ppn
);
    localparam logic [VPN_W-1:0] VPN_ONES = '1;
    localparam logic [PPN_W-1:0] PPN_ONES = '1;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] first_vec;
    logic [ENTRIES:0]   lower_any;

    assign lower_any[0] = 1'b0;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [VPN_W-1:0] ign;
        logic             ctx_ok;
        // low page-number bits covered by this entry's page size are not compared
        assign ign    = ~(VPN_ONES << (4'd3 * {2'b00, datas[i].size}));
        assign ctx_ok = datas[i].glob || (tags[i].ctx == ctx);
        assign hit_vec[i] = datas[i].valid && ctx_ok &&
                            (((tags[i].vpn ^ vpn) & ~ign) == '0);
        assign lower_any[i+1] = lower_any[i] | hit_vec[i];
        assign first_vec[i]   = hit_vec[i] & ~lower_any[i];
    end

    assign hit = lower_any[ENTRIES];

    always_comb begin
        sel_idx = '0;
        sel     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (first_vec[i]) begin
                sel_idx = IDX_W'(i);
                sel     = datas[i];
            end
        end
    end

    logic [PPN_W-1:0] keep_va;
    assign keep_va = ~(PPN_ONES << (4'd3 * {2'b00, sel.size}));
    assign pa_ppn  = (sel.ppn & ~keep_va) | (vpn[PPN_W-1:0] & keep_va);
endmodule

// File: rtl/mmu_tlb_check.sv
module mmu_tlb_check
    import mmu_tlb_pkg::*;
(
    input  acc_kind_e        kind,
    input  logic             user,
    input  logic             hit,
    input  logic             e_priv,
    input  logic             e_side,
    input  logic             e_nfo,
    input  logic             e_wr,
    input  logic [1:0]       ctx_type,
    output exc_e             exc,
    output logic [2:0]       perm,
    output logic [FSR_W-1:0] fields
);
    logic is_fetch, ft_priv, ft_se, ft_nfo, prot;

    always_comb begin
        is_fetch = (kind == ACC_FETCH);
        ft_priv  = e_priv && user;
        ft_se    = (kind == ACC_NFLOAD) && e_side;
        ft_nfo   = !is_fetch && (kind != ACC_NFLOAD) && e_nfo;
        prot     = (kind == ACC_STORE) && !e_wr;

        if (!hit)                           exc = EXC_MISS;
        else if (ft_priv || ft_se || ft_nfo) exc = EXC_FAULT;
        else if (prot)                      exc = EXC_PROT;
        else                                exc = EXC_NONE;

        perm = 3'b000;
        if (exc == EXC_NONE) begin
            perm = is_fetch ? 3'b001 : {1'b1, e_wr, 1'b0};
        end

        fields                          = '0;
        fields[FS_WRITE]                = (kind == ACC_STORE);
        fields[FS_NF]                   = (kind == ACC_NFLOAD);
        fields[FS_CT_LO +: 2]           = ctx_type;
        fields[FS_FT_PRIV]              = ft_priv;
        fields[FS_FT_SE]                = ft_se;
        fields[FS_FT_NFO]               = ft_nfo;
    end
endmodule

// File: rtl/mmu_tlb_lookup.sv
module mmu_tlb_lookup
    import mmu_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VA_W-1:0]    wr_tag,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_kind,
    input  logic [1:0]         req_ctx_sel,
    input  logic               req_user,
    input  logic               req_trap_nz,
    input  logic [CTX_W-1:0]   prim_ctx,
    input  logic [CTX_W-1:0]   sec_ctx,
    output logic               rsp_valid,
    output logic [1:0]         rsp_exc,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [2:0]         rsp_perm,
    output logic [IDX_W-1:0]   rsp_index,
    output logic               rsp_used,
    output logic [FSR_W-1:0]   fault_status,
    output logic [VA_W-1:0]    fault_addr,
    output logic [VA_W-1:0]    tag_access
);
    typedef struct packed {
        logic             rsp_valid;
        exc_e             exc;
        logic [PA_W-1:0]  pa;
        logic [2:0]       perm;
        logic [IDX_W-1:0] idx;
        logic             used;
        acc_kind_e        kind;
        logic [FSR_W-1:0] fsr;
        logic [VA_W-1:0]  far;
        logic [VA_W-1:0]  tac;
    } state_t;

    state_t st_d, st_q;

    acc_kind_e        kind;
    logic [CTX_W-1:0] ctx_sel;
    logic [1:0]       ctx_type;

    always_comb begin
        kind = acc_kind_e'(req_kind);
        if (kind == ACC_FETCH) begin
            ctx_sel  = req_trap_nz ? '0 : prim_ctx;
            ctx_type = req_trap_nz ? CT_NUCLEUS : CT_PRIMARY;
        end else begin
            case (req_ctx_sel)
                2'd0:    begin ctx_sel = prim_ctx; ctx_type = CT_PRIMARY;   end
                2'd1:    begin ctx_sel = sec_ctx;  ctx_type = CT_SECONDARY; end
                default: begin ctx_sel = '0;       ctx_type = CT_NUCLEUS;   end
            endcase
        end
    end

    tlb_tag_t  tags  [ENTRIES];
    tlb_data_t datas [ENTRIES];

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    tlb_data_t        hit_data;
    logic [PPN_W-1:0] pa_ppn;
    exc_e             exc;
    logic [2:0]       perm;
    logic [FSR_W-1:0] fields;
    logic             touch_en;

    mmu_tlb_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (tlb_tag_t'(wr_tag)),
        .wr_data   (tlb_data_t'(wr_data)),
        .touch_en  (touch_en),
        .touch_idx (hit_idx),
        .tags_q    (tags),
        .datas_q   (datas)
    );

    mmu_tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
        .tags    (tags),
        .datas   (datas),
        .vpn     (req_va[VA_W-1:PG_SHIFT]),
        .ctx     (ctx_sel),
        .hit     (hit),
        .sel_idx (hit_idx),
        .sel     (hit_data),
        .pa_ppn  (pa_ppn)
    );

    mmu_tlb_check u_check (
        .kind     (kind),
        .user     (req_user),
        .hit      (hit),
        .e_priv   (hit_data.priv),
        .e_side   (hit_data.side),
        .e_nfo    (hit_data.nfo),
        .e_wr     (hit_data.wr),
        .ctx_type (ctx_type),
        .exc      (exc),
        .perm     (perm),
        .fields   (fields)
    );

    assign touch_en = req_valid && (exc == EXC_NONE);

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        if (req_valid) begin
            st_d.exc  = exc;
            st_d.perm = perm;
            st_d.kind = kind;
            st_d.idx  = hit ? hit_idx : '0;
            st_d.used = hit ? hit_data.used : 1'b0;
            st_d.pa   = (exc == EXC_NONE) ? {pa_ppn, {PG_SHIFT{1'b0}}} : '0;
            if (exc != EXC_NONE) begin
                st_d.tac = {req_va[VA_W-1:PG_SHIFT], ctx_sel};
            end
            if (exc == EXC_FAULT || exc == EXC_PROT) begin
                st_d.fsr           = fields;
                st_d.fsr[FS_VALID] = 1'b1;
                st_d.fsr[FS_OVF]   = st_q.fsr[FS_VALID];
                st_d.far           = req_va;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_exc      = st_q.exc;
    assign rsp_pa       = st_q.pa;
    assign rsp_perm     = st_q.perm;
    assign rsp_index    = st_q.idx;
    assign rsp_used     = st_q.used;
    assign fault_status = st_q.fsr;
    assign fault_addr   = st_q.far;
    assign tag_access   = st_q.tac;

    p_resp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_resp_without_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_no_perm_on_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != EXC_NONE) |-> (rsp_perm == 3'b000 && rsp_pa == '0));
    p_fault_sets_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_exc == EXC_FAULT || rsp_exc == EXC_PROT)) |-> fault_status[FS_VALID]);
    p_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_exc == EXC_FAULT || rsp_exc == EXC_PROT) && $past(fault_status[FS_VALID]))
        |-> fault_status[FS_OVF]);
    p_miss_keeps_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == EXC_MISS) |-> ($stable(fault_status) && $stable(fault_addr)));
    p_fetch_exec_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == EXC_NONE && st_q.kind == ACC_FETCH) |-> (rsp_perm == 3'b001));
    p_data_read_granted_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == EXC_NONE && st_q.kind != ACC_FETCH) |-> (rsp_perm[2] && !rsp_perm[0]));
endmodule

// File: tb/sim_mmu_tlb_lookup.sv
module sim_mmu_tlb_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT      = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [5:0]  wr_idx;
    logic [63:0] wr_tag;
    logic [36:0] wr_data;
    logic        req_valid;
    logic [63:0] req_va;
    logic [1:0]  req_kind;
    logic [1:0]  req_ctx_sel;
    logic        req_user;
    logic        req_trap_nz;
    logic [12:0] prim_ctx;
    logic [12:0] sec_ctx;
    logic        rsp_valid;
    logic [1:0]  rsp_exc;
    logic [40:0] rsp_pa;
    logic [2:0]  rsp_perm;
    logic [5:0]  rsp_index;
    logic        rsp_used;
    logic [8:0]  fault_status;
    logic [63:0] fault_addr;
    logic [63:0] tag_access;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_tlb_lookup u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_data(wr_data), .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind),
        .req_ctx_sel(req_ctx_sel), .req_user(req_user), .req_trap_nz(req_trap_nz),
        .prim_ctx(prim_ctx), .sec_ctx(sec_ctx), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc),
        .rsp_pa(rsp_pa), .rsp_perm(rsp_perm), .rsp_index(rsp_index), .rsp_used(rsp_used),
        .fault_status(fault_status), .fault_addr(fault_addr), .tag_access(tag_access)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model state
    logic [63:0] m_tag  [N_ENT];
    logic [36:0] m_data [N_ENT];
    logic [8:0]  m_fsr;
    logic [63:0] m_far, m_tac;
    logic [1:0]  e_exc;
    logic [40:0] e_pa;
    logic [2:0]  e_perm;
    logic [5:0]  e_idx;
    logic        e_used;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [36:0] mk(input logic [27:0] ppn, input logic [1:0] sz, input bit v,
                                       input bit g, input bit p, input bit w, input bit se, input bit nfo);
        return {1'b0, nfo, se, w, p, g, v, sz, ppn};
    endfunction

    function automatic logic [63:0] page_mask(input logic [1:0] sz);
        return 64'hFFFF_FFFF_FFFF_FFFF << (13 + 3 * int'(sz));
    endfunction

    task automatic do_write(input int idx, input logic [63:0] va, input logic [12:0] ctx, input logic [36:0] d);
        wr_en   = 1'b1;
        wr_idx  = 6'(idx);
        wr_tag  = {va[63:13], ctx};
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_tag[idx]  = {va[63:13], ctx};
        m_data[idx] = d;
    endtask

    task automatic model(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] csel,
                         input bit usr, input bit tl);
        logic [12:0] ctx;
        logic [1:0]  ct;
        logic [36:0] d;
        logic [63:0] vm, pfull;
        bit          found, ftp, ftse, ftnfo, prot;
        int          fi;
        logic [8:0]  f;
        if (kind == 2'd3) begin
            ctx = tl ? 13'd0 : prim_ctx;
            ct  = tl ? 2'd2 : 2'd0;
        end else if (csel == 2'd0) begin
            ctx = prim_ctx; ct = 2'd0;
        end else if (csel == 2'd1) begin
            ctx = sec_ctx;  ct = 2'd1;
        end else begin
            ctx = 13'd0;    ct = 2'd2;
        end
        found = 0; fi = 0; d = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!found) begin
                vm = page_mask(m_data[i][29:28]);
                if (m_data[i][30] && (m_data[i][31] || m_tag[i][12:0] == ctx) &&
                    (((m_tag[i] ^ va) & vm) == 64'h0)) begin
                    found = 1; fi = i; d = m_data[i];
                end
            end
        end
        vm    = page_mask(d[29:28]);
        pfull = {36'h0, d[27:0]} << 13;
        ftp   = d[32] && usr;
        ftse  = (kind == 2'd2) && d[34];
        ftnfo = (kind == 2'd0 || kind == 2'd1) && d[35];
        prot  = (kind == 2'd1) && !d[33];
        e_idx  = found ? 6'(fi) : 6'd0;
        e_used = found ? d[36] : 1'b0;
        e_pa   = '0;
        e_perm = 3'b000;
        if (!found)                    e_exc = 2'd1;
        else if (ftp || ftse || ftnfo) e_exc = 2'd2;
        else if (prot)                 e_exc = 2'd3;
        else                           e_exc = 2'd0;
        if (e_exc == 2'd0) begin
            e_pa   = 41'(((pfull & vm) | (va & ~vm)) & 64'h1FF_FFFF_E000);
            e_perm = (kind == 2'd3) ? 3'b001 : {1'b1, d[33], 1'b0};
            m_data[fi][36] = 1'b1;
        end else begin
            m_tac = {va[63:13], ctx};
        end
        if (e_exc == 2'd2 || e_exc == 2'd3) begin
            f = {ftnfo, ftse, ftp, ct, kind == 2'd2, kind == 2'd1, m_fsr[0], 1'b1};
            m_fsr = f;
            m_far = va;
        end
    endtask

    task automatic lookup(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] csel,
                          input bit usr, input bit tl, input string rq);
        req_valid   = 1'b1;
        req_va      = va;
        req_kind    = kind;
        req_ctx_sel = csel;
        req_user    = usr;
        req_trap_nz = tl;
        model(va, kind, csel, usr, tl);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rq, "exc", 64'(rsp_exc), 64'(e_exc));
        chk(rq, "pa", 64'(rsp_pa), 64'(e_pa));
        chk(rq, "perm", 64'(rsp_perm), 64'(e_perm));
        chk(rq, "index", 64'(rsp_index), 64'(e_idx));
        chk(rq, "used", 64'(rsp_used), 64'(e_used));
        chk(rq, "fault_status", 64'(fault_status), 64'(m_fsr));
        chk(rq, "fault_addr", fault_addr, m_far);
        chk(rq, "tag_access", tag_access, m_tac);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < N_ENT; i++) begin m_tag[i] = '0; m_data[i] = '0; end
        m_fsr = '0; m_far = '0; m_tac = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_tag = '0; wr_data = '0;
        req_valid = 1'b0; req_va = '0; req_kind = '0; req_ctx_sel = '0;
        req_user = 1'b0; req_trap_nz = 1'b0; prim_ctx = 13'd7; sec_ctx = 13'd9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "fault_status", 64'(fault_status), 64'd0);
        chk("R1", "fault_addr", fault_addr, 64'd0);
        chk("R1", "tag_access", tag_access, 64'd0);
        lookup(64'h0000_0000_1000_2000, 2'd0, 2'd0, 0, 0, "R1");

        // R3: idle cycle clears rsp_valid
        @(negedge clk);
        chk("R3", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // R2 R6 R12: small page, load then store
        do_write(5, 64'h0000_0004_0000_6000, 13'd7, mk(28'h0ABCDE, 2'd0, 1, 0, 0, 1, 0, 0));
        lookup(64'h0000_0004_0000_6123, 2'd0, 2'd0, 0, 0, "R6");
        lookup(64'h0000_0004_0000_6FF0, 2'd1, 2'd0, 0, 0, "R12");
        do_write(5, 64'h0000_0004_0000_6000, 13'd7, mk(28'h0555AA, 2'd0, 1, 0, 0, 0, 0, 0));
        lookup(64'h0000_0004_0000_6000, 2'd0, 2'd0, 0, 0, "R2");

        // R4: 4 MB page
        do_write(6, 64'h0000_0008_0000_0000, 13'd7, mk(28'hFFF_FFFF, 2'd3, 1, 0, 0, 1, 0, 0));
        lookup(64'h0000_0008_0012_3456, 2'd0, 2'd0, 0, 0, "R4");
        lookup(64'h0000_0008_0040_0000, 2'd0, 2'd0, 0, 0, "R4");
        // R4: 64 KB and 512 KB pages
        do_write(10, 64'h0000_000A_0001_0000, 13'd7, mk(28'h1234567, 2'd1, 1, 0, 0, 1, 0, 0));
        lookup(64'h0000_000A_0001_E000, 2'd0, 2'd0, 0, 0, "R4");
        do_write(11, 64'h0000_000A_0080_0000, 13'd7, mk(28'h7654321, 2'd2, 1, 0, 0, 1, 0, 0));
        lookup(64'h0000_000A_008F_E000, 2'd0, 2'd0, 0, 0, "R4");
        lookup(64'h0000_000A_0100_0000, 2'd0, 2'd0, 0, 0, "R4");

        // R5: context selection and global
        do_write(7, 64'h0000_000C_0001_0000, 13'd9, mk(28'h0000111, 2'd1, 1, 0, 0, 1, 0, 0));
        lookup(64'h0000_000C_0001_2000, 2'd0, 2'd0, 0, 0, "R5");
        lookup(64'h0000_000C_0001_2000, 2'd0, 2'd1, 0, 0, "R5");
        do_write(8, 64'h0000_000C_0100_0000, 13'd3, mk(28'h0000222, 2'd0, 1, 1, 0, 0, 0, 0));
        lookup(64'h0000_000C_0100_0000, 2'd0, 2'd2, 0, 0, "R5");

        // R7: lowest index wins
        do_write(20, 64'h0000_0010_0000_0000, 13'd7, mk(28'h0000020, 2'd0, 1, 0, 0, 1, 0, 0));
        do_write(12, 64'h0000_0010_0000_0000, 13'd7, mk(28'h0000012, 2'd0, 1, 0, 0, 1, 0, 0));
        lookup(64'h0000_0010_0000_0000, 2'd0, 2'd0, 0, 0, "R7");
        do_write(12, 64'h0000_0010_0000_0000, 13'd7, mk(28'h0000012, 2'd0, 0, 0, 0, 1, 0, 0));
        lookup(64'h0000_0010_0000_0000, 2'd0, 2'd0, 0, 0, "R7");

        // R8 R10: faults and overflow
        do_write(30, 64'h0000_0014_0000_0000, 13'd7, mk(28'h0000030, 2'd0, 1, 0, 1, 1, 0, 0));
        lookup(64'h0000_0014_0000_0000, 2'd0, 2'd0, 1, 0, "R8");
        lookup(64'h0000_0014_0000_0000, 2'd1, 2'd0, 1, 0, "R10");
        lookup(64'h0000_0014_0000_0000, 2'd0, 2'd0, 0, 0, "R8");
        do_write(31, 64'h0000_0018_0000_0000, 13'd7, mk(28'h0000031, 2'd0, 1, 0, 0, 1, 1, 0));
        lookup(64'h0000_0018_0000_0000, 2'd2, 2'd1, 0, 0, "R8");
        do_write(31, 64'h0000_0018_0000_0000, 13'd9, mk(28'h0000031, 2'd0, 1, 0, 0, 1, 1, 0));
        lookup(64'h0000_0018_0000_0000, 2'd2, 2'd1, 0, 0, "R10");
        lookup(64'h0000_0018_0000_0000, 2'd0, 2'd1, 0, 0, "R8");
        do_write(32, 64'h0000_001C_0000_0000, 13'd7, mk(28'h0000032, 2'd0, 1, 0, 0, 1, 0, 1));
        lookup(64'h0000_001C_0000_0000, 2'd0, 2'd0, 0, 0, "R8");
        lookup(64'h0000_001C_0000_0000, 2'd2, 2'd0, 0, 0, "R8");

        // R9: protection versus fault precedence
        do_write(33, 64'h0000_0020_0000_0000, 13'd7, mk(28'h0000033, 2'd0, 1, 0, 0, 0, 0, 0));
        lookup(64'h0000_0020_0000_0000, 2'd1, 2'd0, 0, 0, "R9");
        do_write(34, 64'h0000_0024_0000_0000, 13'd7, mk(28'h0000034, 2'd0, 1, 0, 0, 0, 0, 1));
        lookup(64'h0000_0024_0000_0000, 2'd1, 2'd0, 0, 0, "R9");

        // R11: miss keeps status and address, updates tag access
        lookup(64'h0000_7777_0000_0000, 2'd1, 2'd1, 0, 0, "R11");

        // R12 R13: fetch
        do_write(40, 64'h0000_0028_0000_0000, 13'd7, mk(28'h0000040, 2'd0, 1, 0, 0, 1, 0, 1));
        lookup(64'h0000_0028_0000_0000, 2'd3, 2'd2, 0, 0, "R12");
        lookup(64'h0000_0028_0000_0000, 2'd3, 2'd0, 0, 1, "R13");
        do_write(41, 64'h0000_0028_0000_0000, 13'd0, mk(28'h0000041, 2'd0, 1, 0, 1, 0, 0, 0));
        lookup(64'h0000_0028_0000_0000, 2'd3, 2'd0, 1, 1, "R13");
        lookup(64'h0000_0028_0000_0000, 2'd3, 2'd0, 0, 1, "R13");
        lookup(64'h0000_0028_0000_0000, 2'd3, 2'd0, 0, 1, "R12");

        // random mix
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(0, 9) == 0) begin
                logic [63:0] va;
                logic [36:0] d;
                va = {30'h0, 2'($urandom_range(0, 3)), 32'($urandom)} & ~64'h1FFF;
                d  = mk(28'($urandom), 2'($urandom_range(0, 3)), $urandom_range(0, 7) != 0,
                        $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                        $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0);
                do_write($urandom_range(0, N_ENT - 1), va, 13'($urandom_range(0, 3)), d);
            end else begin
                logic [63:0] va, vm;
                int          k;
                prim_ctx = 13'($urandom_range(0, 3));
                sec_ctx  = 13'($urandom_range(0, 3));
                if ($urandom_range(0, 1) == 1) begin
                    k  = $urandom_range(0, N_ENT - 1);
                    vm = page_mask(m_data[k][29:28]);
                    va = (m_tag[k] & vm) | ({$urandom, $urandom} & ~vm);
                end else begin
                    va = {30'h0, 2'($urandom_range(0, 3)), 32'($urandom)};
                end
                lookup(va, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                       $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, "R4 R5 R6 R8");
            end
        end

        finish_run();
    end
endmodule